// File: doc/BRIEF.md
# Configuration Load Sequencer

This block is the control state machine that brings a programmable logic device from power-on to a running configuration. First it waits until the core, auxiliary and I/O supplies all report good. It then sweeps through its configuration storage to clear it. After that it waits on a shared open-drain init line, which any outside agent may hold low to delay configuration. When the line is free, the block latches the load-mode pins and takes in a stream of 32-bit configuration words. It keeps a running CRC over the words and compares it with the last word of the stream. A match brings the device to the configured state. A mismatch stops startup, and the block pulls the init line low to report the error.

While unconfigured, the block keeps the user clock enable off, sets the user outputs to high impedance and asserts the weak pull-up indication. A program request restarts the flow at the clear sweep. The request must be low for at least two cycles after synchronisation. A drop in any supply sends the flow back to waiting for power.

The states are ST_PWR_WAIT, ST_CLEAR, ST_INIT_WAIT, ST_MODE_SAMPLE, ST_LOAD, ST_CRC_CHECK, ST_DONE and ST_ERROR. The transitions are listed below.

- Power loss: any state to ST_PWR_WAIT.
- Program restart: any state other than ST_PWR_WAIT to ST_CLEAR.
- Power good: ST_PWR_WAIT to ST_CLEAR.
- Sweep end: ST_CLEAR to ST_INIT_WAIT.
- Init released: ST_INIT_WAIT to ST_MODE_SAMPLE.
- Mode latched: ST_MODE_SAMPLE to ST_LOAD.
- Last word: ST_LOAD to ST_CRC_CHECK.
- CRC match: ST_CRC_CHECK to ST_DONE.
- CRC mismatch: ST_CRC_CHECK to ST_ERROR.

Top module: `cfg_load_seq`

## Requirements
- R1: After reset, and in every cycle where any of pwr_core_ok, pwr_aux_ok or pwr_io_ok is low, the sequencer sits in ST_PWR_WAIT with done low and init_drive_low high. A partial set of good supplies starts nothing.
- R2: Once all three supplies are good, the sequencer spends exactly CLEAR_DEPTH cycles in the clear sweep (default 16) with init_drive_low high, then releases init_drive_low.
- R3: After the sweep, init_drive_low stays low and the sequencer waits for as long as init_in reads 0. It moves on at the first clock edge where init_in reads 1.
- R4: One cycle after init is seen high, mode_sel is latched into load_mode. The codes are 00 for a JTAG load, 01 for a flash load with this device as master, 10 for a flash load with the flash as master, and 11 for reserved. load_mode then ignores mode_sel until the next pass through that step.
- R5: In the load step, every word with cfg_valid=1 and cfg_last=0 is folded into a CRC-32: polynomial 0x04C11DB7, seed 0xFFFFFFFF, data bit 31 first, no reflection, no final inversion. Cycles with cfg_valid=0 are ignored. The word with cfg_valid=1 and cfg_last=1 carries the expected CRC, and a stream made of that word alone is valid.
- R6: When the CRC matches, done rises at the clock edge after the one that accepts the last word, and it then stays high.
- R7: When the CRC does not match, done stays low and init_drive_low goes high at the same edge. Both hold until a program request or a supply loss.
- R8: user_clk_en is high exactly when done is high. io_tristate and io_pullup are high exactly when done is low.
- R9: prog_req_n passes through a two-flop synchroniser. A low level present at two consecutive clock edges returns the sequencer to the clear sweep from any state other than ST_PWR_WAIT. The sweep restarts as long as the low level lasts. A low pulse of a single cycle is ignored.
- R10: A loss of any supply takes priority over everything else and returns the sequencer to ST_PWR_WAIT at the next clock edge.
- R11: Words presented while configured are ignored: done stays high and load_mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_core_ok | input | 1 | Core supply good |
| pwr_aux_ok | input | 1 | Auxiliary supply good |
| pwr_io_ok | input | 1 | I/O supply good |
| prog_req_n | input | 1 | Active-low program request, asynchronous |
| init_in | input | 1 | Level read back from the open-drain init line |
| init_drive_low | output | 1 | Pulls the open-drain init line low when high |
| mode_sel | input | 2 | Load-mode pins |
| cfg_data | input | 32 | Configuration word |
| cfg_valid | input | 1 | cfg_data carries a word this cycle |
| cfg_last | input | 1 | The current word is the expected CRC |
| done | output | 1 | Configuration loaded and checked |
| user_clk_en | output | 1 | Lets clocks reach user logic |
| io_tristate | output | 1 | User outputs held at high impedance |
| io_pullup | output | 1 | Weak pull-ups on user I/O enabled |
| load_mode | output | 2 | Latched load-mode code |

## Verification
All outputs are decoded from the state register, so a wrong state shows at the ports in the same cycle it is entered. The bench compares every clock against a behavioural reference, which catches a wrong state within one cycle. A stale clear counter shows up as init_drive_low being released one or more cycles early or late. A corrupted CRC accumulator stays hidden until the edge after the last word, and then sends the flow to ST_ERROR where ST_DONE was expected (or the reverse). A mishandled program request shows three edges after the request enters the synchroniser.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    localparam int WORD_W = 32;
    localparam int CRC_W  = 32;
    localparam int MODE_W = 2;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        ST_PWR_WAIT,
        ST_CLEAR,
        ST_INIT_WAIT,
        ST_MODE_SAMPLE,
        ST_LOAD,
        ST_CRC_CHECK,
        ST_DONE,
        ST_ERROR
    } seq_state_t;

    // Shift one data word into the CRC register, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] crc_in,
                                                  input logic [WORD_W-1:0] word);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ word[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) begin
                c = c ^ CRC_POLY;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_prog_filter.sv
module cfg_prog_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic req_hold
);
    localparam int CHAIN = SYNC_STAGES + MIN_LOW - 1;

    logic [CHAIN-1:0] chain_q;

    // Stage 0 samples the pin; each later stage delays the previous one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], req_n_async};
        end
    end

    // Request accepted when the last MIN_LOW synchronised samples are all low.
    assign req_hold = ~|chain_q[CHAIN-1 -: MIN_LOW];

endmodule

// File: rtl/cfg_clear_sweep.sv
module cfg_clear_sweep #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    output logic last
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;

    assign last = active && (addr_q == LAST_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (active && !restart && !last) begin
            addr_q <= addr_q + AW'(1);
        end else begin
            addr_q <= '0;
        end
    end

endmodule

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc
    import cfg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic              fold_en,
    input  logic [WORD_W-1:0] word,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (seed_load) begin
            crc_q <= CRC_SEED;
        end else if (fold_en) begin
            crc_q <= crc_fold(crc_q, word);
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLEAR_DEPTH      = 16,
    parameter int PROG_SYNC_STAGES = 2,
    parameter int PROG_MIN_LOW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_core_ok,
    input  logic              pwr_aux_ok,
    input  logic              pwr_io_ok,
    input  logic              prog_req_n,
    input  logic              init_in,
    output logic              init_drive_low,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [WORD_W-1:0] cfg_data,
    input  logic              cfg_valid,
    input  logic              cfg_last,
    output logic              done,
    output logic              user_clk_en,
    output logic              io_tristate,
    output logic              io_pullup,
    output logic [MODE_W-1:0] load_mode
);

    seq_state_t        state_q, state_d;
    logic              pwr_all;
    logic              prog_hold;
    logic              sweep_last;
    logic [CRC_W-1:0]  crc_now;
    logic [WORD_W-1:0] expect_q;
    logic [MODE_W-1:0] mode_q;
    logic              word_fold;
    logic              word_final;

    assign pwr_all    = pwr_core_ok & pwr_aux_ok & pwr_io_ok;
    assign word_fold  = (state_q == ST_LOAD) && cfg_valid && !cfg_last;
    assign word_final = (state_q == ST_LOAD) && cfg_valid && cfg_last;

    cfg_prog_filter #(
        .SYNC_STAGES (PROG_SYNC_STAGES),
        .MIN_LOW     (PROG_MIN_LOW)
    ) prog_filt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_n_async (prog_req_n),
        .req_hold    (prog_hold)
    );

    cfg_clear_sweep #(
        .DEPTH   (CLEAR_DEPTH)
    ) sweep_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == ST_CLEAR),
        .restart (prog_hold),
        .last    (sweep_last)
    );

    cfg_crc_acc crc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (state_q == ST_MODE_SAMPLE),
        .fold_en   (word_fold),
        .word      (cfg_data),
        .crc       (crc_now)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: supply loss first, then program restart, then the flow.
    always_comb begin
        state_d = state_q;
        if (!pwr_all) begin
            state_d = ST_PWR_WAIT;
        end else if (prog_hold && (state_q != ST_PWR_WAIT)) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_PWR_WAIT:    state_d = ST_CLEAR;
                ST_CLEAR:       if (sweep_last) state_d = ST_INIT_WAIT;
                ST_INIT_WAIT:   if (init_in) state_d = ST_MODE_SAMPLE;
                ST_MODE_SAMPLE: state_d = ST_LOAD;
                ST_LOAD:        if (word_final) state_d = ST_CRC_CHECK;
                ST_CRC_CHECK:   state_d = (crc_now == expect_q) ? ST_DONE : ST_ERROR;
                ST_DONE:        state_d = ST_DONE;
                ST_ERROR:       state_d = ST_ERROR;
                default:        state_d = ST_PWR_WAIT;
            endcase
        end
    end

    // Data registers captured in particular states.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            expect_q <= '0;
        end else begin
            if (state_q == ST_MODE_SAMPLE) begin
                mode_q <= mode_sel;
            end
            if (word_final) begin
                expect_q <= cfg_data;
            end
        end
    end

    // Outputs, decoded from the state.
    always_comb begin
        done           = 1'b0;
        init_drive_low = 1'b0;
        unique case (state_q)
            ST_PWR_WAIT,
            ST_CLEAR,
            ST_ERROR:       init_drive_low = 1'b1;
            ST_DONE:        done = 1'b1;
            ST_INIT_WAIT,
            ST_MODE_SAMPLE,
            ST_LOAD,
            ST_CRC_CHECK:   init_drive_low = 1'b0;
            default:        init_drive_low = 1'b1;
        endcase
        user_clk_en = done;
        io_tristate = !done;
        io_pullup   = !done;
        load_mode   = mode_q;
    end

endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_core_ok,
    input logic       pwr_aux_ok,
    input logic       pwr_io_ok,
    input logic       init_drive_low,
    input logic       done,
    input logic       user_clk_en,
    input logic       io_tristate,
    input logic       io_pullup,
    input logic [1:0] load_mode
);
    logic pwr_all;
    assign pwr_all = pwr_core_ok & pwr_aux_ok & pwr_io_ok;

    AST_DONE_OPENS_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (user_clk_en && !io_tristate && !io_pullup)); // R8

    AST_IDLE_KEEPS_PINS_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!user_clk_en && io_tristate && io_pullup)); // R8

    AST_PWR_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_all |=> (!done && init_drive_low)); // R10

    AST_DONE_RELEASES_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !init_drive_low); // R7

    AST_MODE_HELD_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(load_mode)); // R4

    AST_DONE_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(pwr_all)); // R1

endmodule

bind cfg_load_seq cfg_load_seq_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_core_ok    (pwr_core_ok),
    .pwr_aux_ok     (pwr_aux_ok),
    .pwr_io_ok      (pwr_io_ok),
    .init_drive_low (init_drive_low),
    .done           (done),
    .user_clk_en    (user_clk_en),
    .io_tristate    (io_tristate),
    .io_pullup      (io_pullup),
    .load_mode      (load_mode)
);

// File: tb/cfg_load_seq_tb_top.sv
module cfg_load_seq_tb_top;

    localparam int DEPTH    = 16;
    localparam int WD_LIMIT = 20000;

    localparam int M_PWR   = 0;
    localparam int M_CLEAR = 1;
    localparam int M_INITW = 2;
    localparam int M_MODE  = 3;
    localparam int M_LOAD  = 4;
    localparam int M_CHECK = 5;
    localparam int M_DONE  = 6;
    localparam int M_ERR   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_core_ok = 1'b0, pwr_aux_ok = 1'b0, pwr_io_ok = 1'b0;
    logic        prog_req_n = 1'b1;
    logic        ext_hold_low = 1'b0;
    logic        init_in;
    logic        init_drive_low;
    logic [1:0]  mode_sel = 2'b00;
    logic [31:0] cfg_data = '0;
    logic        cfg_valid = 1'b0, cfg_last = 1'b0;
    logic        done, user_clk_en, io_tristate, io_pullup;
    logic [1:0]  load_mode;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Reference model state.
    int          mstate = M_PWR;
    int          mcnt   = 0;
    logic [31:0] mcrc   = 32'hFFFF_FFFF;
    logic [31:0] mexp   = '0;
    logic [1:0]  mmode  = 2'b00;
    bit          phist[$] = '{1'b1, 1'b1, 1'b1};

    // Open-drain wire-AND of the block's pull-down and an external agent.
    assign init_in = !(ext_hold_low || init_drive_low);

    always #10 clk = ~clk;

    cfg_load_seq #(.CLEAR_DEPTH(DEPTH)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_core_ok    (pwr_core_ok),
        .pwr_aux_ok     (pwr_aux_ok),
        .pwr_io_ok      (pwr_io_ok),
        .prog_req_n     (prog_req_n),
        .init_in        (init_in),
        .init_drive_low (init_drive_low),
        .mode_sel       (mode_sel),
        .cfg_data       (cfg_data),
        .cfg_valid      (cfg_valid),
        .cfg_last       (cfg_last),
        .done           (done),
        .user_clk_en    (user_clk_en),
        .io_tristate    (io_tristate),
        .io_pullup      (io_pullup),
        .load_mode      (load_mode)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        for (int k = 0; k < 32; k++) begin
            if (r[31] != w[31-k]) r = (r << 1) ^ 32'h04C1_1DB7;
            else                  r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Reference model, advanced on each rising edge from sampled inputs.
    always @(posedge clk) begin
        bit hold;
        cycles++;
        if (!rst_n) begin
            mstate = M_PWR; mcnt = 0; mmode = 2'b00; mcrc = 32'hFFFF_FFFF;
            phist = '{1'b1, 1'b1, 1'b1};
        end else begin
            hold = !phist[1] && !phist[2];
            phist.push_front(prog_req_n);
            void'(phist.pop_back());
            if (!(pwr_core_ok && pwr_aux_ok && pwr_io_ok)) begin
                mstate = M_PWR; mcnt = 0;
            end else if (hold && mstate != M_PWR) begin
                mstate = M_CLEAR; mcnt = 0;
            end else begin
                case (mstate)
                    M_PWR:   begin mstate = M_CLEAR; mcnt = 0; end
                    M_CLEAR: if (mcnt == DEPTH - 1) mstate = M_INITW; else mcnt++;
                    M_INITW: if (init_in) mstate = M_MODE;
                    M_MODE:  begin mmode = mode_sel; mcrc = 32'hFFFF_FFFF; mstate = M_LOAD; end
                    M_LOAD:  if (cfg_valid) begin
                                 if (cfg_last) begin mexp = cfg_data; mstate = M_CHECK; end
                                 else mcrc = ref_crc(mcrc, cfg_data);
                             end
                    M_CHECK: mstate = (mcrc == mexp) ? M_DONE : M_ERR;
                    default: ;
                endcase
            end
        end
    end

    function automatic string state_tag(input int s);
        case (s)
            M_PWR:   return "R1";
            M_CLEAR: return "R2";
            M_INITW: return "R3";
            M_DONE:  return "R6";
            M_ERR:   return "R7";
            default: return "R5";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_done, e_low;
            e_done = (mstate == M_DONE);
            e_low  = (mstate == M_PWR) || (mstate == M_CLEAR) || (mstate == M_ERR);
            check(done == e_done, {state_tag(mstate), " done"}, done, e_done);
            check(init_drive_low == e_low, {state_tag(mstate), " init_drive_low"}, init_drive_low, e_low);
            check(user_clk_en == e_done, "R8 user_clk_en", user_clk_en, e_done);
            check(io_tristate == !e_done && io_pullup == !e_done, "R8 tristate/pullup",
                  {io_tristate, io_pullup}, {!e_done, !e_done});
            check(load_mode == mmode, "R4 load_mode", load_mode, mmode);
        end
        if (cycles > WD_LIMIT && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WD_LIMIT);
            finish_run();
        end
    end

    task automatic wait_state(input int s);
        while (mstate != s) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] d, input bit last);
        cfg_valid = 1'b1; cfg_data = d; cfg_last = last;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_last = 1'b0;
    endtask

    // Sends n words plus a CRC word, optionally corrupted; gaps carry junk.
    task automatic send_stream(input int n, input int seed, input bit corrupt);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = 32'h1357_9BDF * (i + seed) ^ 32'hA5A5_0F0F;
            send_word(w, 1'b0);
            c = ref_crc(c, w);
            cfg_data = ~w;          // R5 idle cycle with junk data, valid low
            @(negedge clk);
        end
        send_word(corrupt ? (c ^ 32'h0000_0100) : c, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && init_drive_low == 1'b1, "R1 reset state", {done, init_drive_low}, 2'b01);

        // Partial supplies: nothing starts.
        pwr_core_ok = 1'b1; pwr_aux_ok = 1'b1;
        repeat (5) @(negedge clk);
        check(init_drive_low == 1'b1 && mstate == M_PWR, "R1 partial supplies", init_drive_low, 1);

        // Full power with init held low externally.
        ext_hold_low = 1'b1;
        mode_sel = 2'b01;
        pwr_io_ok = 1'b1;
        wait_state(M_INITW);
        repeat (10) @(negedge clk);
        check(init_drive_low == 1'b0 && done == 1'b0, "R3 init held by external agent",
              {init_drive_low, done}, 2'b00);
        ext_hold_low = 1'b0;
        wait_state(M_LOAD);
        mode_sel = 2'b11;
        send_stream(5, 1, 1'b0);
        check(done == 1'b0, "R6 done one edge after last word", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R6 done after good CRC", done, 1);
        check(load_mode == 2'b01, "R4 mode latched once", load_mode, 2'b01);

        // Words while configured are ignored.
        send_word(32'hDEAD_BEEF, 1'b0);
        send_word(32'h0, 1'b1);
        repeat (3) @(negedge clk);
        check(done == 1'b1 && load_mode == 2'b01, "R11 words ignored when done",
              {done, load_mode}, 3'b101);

        // Single-cycle program pulse: ignored.
        prog_req_n = 1'b0;
        @(negedge clk);
        prog_req_n = 1'b1;
        repeat (6) @(negedge clk);
        check(done == 1'b1, "R9 short program pulse ignored", done, 1);

        // Held program request: restart and hold in the clear sweep.
        mode_sel = 2'b10;
        prog_req_n = 1'b0;
        repeat (8) @(negedge clk);
        check(done == 1'b0 && init_drive_low == 1'b1, "R9 program request restarts",
              {done, init_drive_low}, 2'b01);
        prog_req_n = 1'b1;
        wait_state(M_LOAD);
        send_stream(4, 7, 1'b1);
        repeat (2) @(negedge clk);
        check(init_drive_low == 1'b1 && done == 1'b0, "R7 CRC error drives init low",
              {init_drive_low, done}, 2'b10);
        check(load_mode == 2'b10, "R4 flash external-master code", load_mode, 2'b10);
        repeat (10) @(negedge clk);
        check(init_drive_low == 1'b1 && done == 1'b0, "R7 error persists",
              {init_drive_low, done}, 2'b10);

        // Restart into an empty stream: CRC is the seed.
        mode_sel = 2'b00;
        prog_req_n = 1'b0;
        repeat (3) @(negedge clk);
        prog_req_n = 1'b1;
        wait_state(M_LOAD);
        repeat (2) @(negedge clk);
        send_word(32'hFFFF_FFFF, 1'b1);
        @(negedge clk);
        check(done == 1'b1 && load_mode == 2'b00, "R5 empty stream accepted",
              {done, load_mode}, 3'b100);

        // Supply loss overrides a simultaneous program request.
        pwr_aux_ok = 1'b0;
        prog_req_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && init_drive_low == 1'b1, "R10 supply loss", {done, init_drive_low}, 2'b01);
        repeat (6) @(negedge clk);
        check(mstate == M_PWR && init_drive_low == 1'b1, "R10 held in power wait", init_drive_low, 1);
        prog_req_n = 1'b1;
        pwr_aux_ok = 1'b1;
        repeat (4) @(negedge clk);
        pwr_core_ok = 1'b0;
        @(negedge clk);
        check(init_drive_low == 1'b1 && done == 1'b0, "R10 loss during clear sweep",
              {init_drive_low, done}, 2'b10);
        pwr_core_ok = 1'b1;
        wait_state(M_LOAD);
        send_stream(2, 3, 1'b0);
        @(negedge clk);
        check(done == 1'b1, "R2 full flow after interrupted sweep", done, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule